// File: doc/BRIEF.md
# Barrel Shifter with Exponent Detect

This block is the shift unit of a 16-bit fixed-point datapath. It takes one data word, an operation code and a signed shift amount. It writes a 32-bit result register that holds a high and a low half. The word is first placed in one half of a 32-bit field. It is then shifted left or right by up to 32 places, so that bits leaving one half land in the other half instead of being lost. This lets software build shifts of values wider than one word from two passes, one per word.

Beyond plain logical and arithmetic shifts, the unit finds the exponent of a word. The exponent is the count of copies of the sign bit that carry no information. The unit can normalize a word by shifting those bits out, and can denormalize a word by shifting it right by a given exponent. A block-exponent register keeps the smallest exponent seen since it was last cleared. Software can then scale a whole array of words by one common exponent (block floating point).

All results are registered. An operation presented with `opValid` high is visible on the outputs one rising clock edge later.

Top module: `bshift_top`

## Requirements
- R1: While `rstN` is low at a rising edge, `result` becomes 0, `expOut` becomes 0 and `blkExp` becomes 15.
- R2: `opCode` encodings are 0 logical shift, 1 arithmetic shift, 2 normalize, 3 denormalize, 4 derive exponent. A valid operation updates the outputs at the next rising edge. When `opValid` is low, or `opCode` is 5, 6 or 7, `result` and `expOut` keep their values.
- R3: For the shift and denormalize operations, `posLo`=0 places the word in bits 31:16 with bits 15:0 zero. `posLo`=1 places it in bits 15:0, and bits 31:16 are filled with the word's bit 15 for arithmetic shift and denormalize, or with zeros for logical shift.
- R4: `shiftAmt` is a 6-bit two's complement value from -32 to +31. A positive value shifts the placed field left with zero fill. A negative value shifts it right by its magnitude. Bits moved past bit 31 or below bit 0 are discarded.
- R5: A logical right shift fills vacated upper bits with zeros. An arithmetic right shift fills them with bit 31 of the placed field.
- R6: Derive exponent sets `expOut` to the number of bits below bit 15 that equal bit 15 before the first differing bit, giving 15 for 0x0000 and 0xFFFF. It leaves `result` unchanged.
- R7: Normalize sets `expOut` to the derived exponent of the word. It sets `result` to the word placed in bits 31:16 and shifted left by that exponent. `posLo` and `shiftAmt` have no effect.
- R8: Denormalize is an arithmetic shift right by `shiftAmt` when it is zero or positive. When it is negative, it is a left shift by its magnitude, and -32 gives 0.
- R9: On normalize or derive exponent, `blkExp` takes the smaller of its value and the derived exponent. `blkClr` sets it to 15. When `blkClr` comes with one of those operations, it takes the derived exponent.
- R10: Logical shift, arithmetic shift, denormalize and idle cycles leave `blkExp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select |
| posLo | input | 1 | Place word in low half (1) or high half (0) |
| dataIn | input | 16 | Input data word |
| shiftAmt | input | 6 | Signed shift amount or exponent |
| blkClr | input | 1 | Reset block exponent to 15 |
| result | output | 32 | Shifted result, high and low halves |
| expOut | output | 4 | Last derived exponent |
| blkExp | output | 4 | Minimum derived exponent since clear |

## Verification
Derive exponent is swept over all 65536 words. This covers the all-zeros and all-ones words that must give 15 rather than 16, and the 0x8000 and 0x7FFF words where an off-by-one count would normalize one place too far or too short. Every shift amount from -32 to +31 is applied in both placements to words with the sign set and clear. A shifter that dropped the 32-place stage, or filled arithmetic right shifts with zeros, shows wrong upper bits. A denormalize by -32 that wrapped would return the input instead of 0. The block exponent is cleared together with a derive-exponent operation, and is then followed by plain shifts. A design that lets the clear win, or lets shifts touch the register, reports 15 or a stale minimum.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXPD   = 3'd4
  } shOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRes;
    logic loadExp;
    logic useExp;
    logic negAmt;
    logic arith;
    logic placeLo;
    logic clrBlk;
  } shStrobe_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       posLo,
  input  logic       blkClr,
  output shStrobe_t  strb
);

  always_comb begin
    strb        = '0;
    strb.clrBlk = blkClr;
    if (opValid) begin
      case (shOp_e'(opCode))
        OP_LSH: begin
          strb.loadRes = 1'b1;
          strb.placeLo = posLo;
        end
        OP_ASH: begin
          strb.loadRes = 1'b1;
          strb.arith   = 1'b1;
          strb.placeLo = posLo;
        end
        OP_NORM: begin
          strb.loadRes = 1'b1;
          strb.loadExp = 1'b1;
          strb.useExp  = 1'b1;
          strb.arith   = 1'b1;
        end
        OP_DENORM: begin
          strb.loadRes = 1'b1;
          strb.arith   = 1'b1;
          strb.negAmt  = 1'b1;
          strb.placeLo = posLo;
        end
        OP_EXPD: strb.loadExp = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bshift_dp.sv
module bshift_dp
  import bshift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  shStrobe_t                 strb,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic [AMT_W-1:0]          shiftAmt,
  output logic [2*DATA_W-1:0]       result,
  output logic [$clog2(DATA_W)-1:0] expOut,
  output logic [$clog2(DATA_W)-1:0] blkExp
);

  localparam int RES_W = 2 * DATA_W;
  localparam int EXP_W = $clog2(DATA_W);
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(DATA_W - 1);

  // redundant sign bit count
  logic [EXP_W-1:0] expDet;
  logic             runOn;
  always_comb begin
    expDet = '0;
    runOn  = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (runOn && (dataIn[i] == dataIn[DATA_W-1])) expDet = expDet + EXP_W'(1);
      else runOn = 1'b0;
    end
  end

  // place word into the 32-bit field
  logic             hiFill;
  logic [RES_W-1:0] placed;
  assign hiFill = strb.arith & dataIn[DATA_W-1];
  assign placed = strb.placeLo ? {{DATA_W{hiFill}}, dataIn}
                               : {dataIn, {DATA_W{1'b0}}};

  // signed effective amount, positive = left
  logic signed [AMT_W:0] amtS, effAmt, negEff;
  logic                  goLeft;
  logic [AMT_W-1:0]      mag;
  always_comb begin
    amtS   = strb.useExp ? signed'({{(AMT_W + 1 - EXP_W){1'b0}}, expDet})
                         : signed'({shiftAmt[AMT_W-1], shiftAmt});
    effAmt = strb.negAmt ? -amtS : amtS;
    negEff = -effAmt;
    goLeft = ~effAmt[AMT_W];
    mag    = goLeft ? effAmt[AMT_W-1:0] : negEff[AMT_W-1:0];
  end

  // logarithmic barrel, one stage per amount bit
  logic             rFill;
  logic [RES_W-1:0] lStg [0:AMT_W];
  logic [RES_W-1:0] rStg [0:AMT_W];
  assign rFill   = strb.arith & placed[RES_W-1];
  assign lStg[0] = placed;
  assign rStg[0] = placed;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [2*RES_W-1:0] lWide, rWide;
    assign lWide      = {{RES_W{1'b0}}, lStg[k]} << SH;
    assign rWide      = {{RES_W{rFill}}, rStg[k]} >> SH;
    assign lStg[k+1]  = mag[k] ? lWide[RES_W-1:0] : lStg[k];
    assign rStg[k+1]  = mag[k] ? rWide[RES_W-1:0] : rStg[k];
  end

  logic [RES_W-1:0] shifted;
  assign shifted = goLeft ? lStg[AMT_W] : rStg[AMT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      expOut <= '0;
      blkExp <= EXP_MAX;
    end else begin
      if (strb.loadRes) result <= shifted;
      if (strb.loadExp) expOut <= expDet;
      if (strb.clrBlk) blkExp <= strb.loadExp ? expDet : EXP_MAX;
      else if (strb.loadExp && (expDet < blkExp)) blkExp <= expDet;
    end
  end

endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      opValid,
  input  logic [2:0]                opCode,
  input  logic                      posLo,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic [AMT_W-1:0]          shiftAmt,
  input  logic                      blkClr,
  output logic [2*DATA_W-1:0]       result,
  output logic [$clog2(DATA_W)-1:0] expOut,
  output logic [$clog2(DATA_W)-1:0] blkExp
);

  shStrobe_t strb;

  bshift_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .posLo   (posLo),
    .blkClr  (blkClr),
    .strb    (strb)
  );

  bshift_dp #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .result   (result),
    .expOut   (expOut),
    .blkExp   (blkExp)
  );

endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      opValid,
  input logic [2:0]                opCode,
  input logic                      posLo,
  input logic [DATA_W-1:0]         dataIn,
  input logic [AMT_W-1:0]          shiftAmt,
  input logic                      blkClr,
  input logic [2*DATA_W-1:0]       result,
  input logic [$clog2(DATA_W)-1:0] expOut,
  input logic [$clog2(DATA_W)-1:0] blkExp
);

  localparam int RES_W = 2 * DATA_W;
  localparam int EXP_W = $clog2(DATA_W);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opCode > 3'd4) |=> ($stable(result) && $stable(expOut)));

  // R6
  expd_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd4) |=> $stable(result));

  // R7
  norm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd2 && dataIn != '0) |=> (result[RES_W-1] != result[RES_W-2]));

  // R3
  lsh_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0 && !posLo && shiftAmt == '0)
      |=> (result == {$past(dataIn), {DATA_W{1'b0}}}));

  // R9
  blk_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blkClr |=> (blkExp <= $past(blkExp)));

  // R9
  blk_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkClr && !(opValid && (opCode == 3'd2 || opCode == 3'd4)))
      |=> (blkExp == EXP_W'(DATA_W - 1)));

  // R10
  blk_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!blkClr && !(opValid && (opCode == 3'd2 || opCode == 3'd4))) |=> $stable(blkExp));

endmodule

bind bshift_top bshift_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .posLo    (posLo),
  .dataIn   (dataIn),
  .shiftAmt (shiftAmt),
  .blkClr   (blkClr),
  .result   (result),
  .expOut   (expOut),
  .blkExp   (blkExp)
);

// File: tb/bshift_top_bench.sv
module bshift_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        posLo = 1'b0;
  logic [15:0] dataIn = '0;
  logic [5:0]  shiftAmt = '0;
  logic        blkClr = 1'b0;
  logic [31:0] result;
  logic [3:0]  expOut;
  logic [3:0]  blkExp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] mRes = '0;
  logic [3:0]  mExp = '0;
  logic [3:0]  mBlk = 4'd15;

  always #2 clk = ~clk;

  bshift_top u_bshift_top (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .posLo(posLo),
    .dataIn(dataIn), .shiftAmt(shiftAmt), .blkClr(blkClr),
    .result(result), .expOut(expOut), .blkExp(blkExp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // exponent from signed range: largest k with value inside [-2^(15-k), 2^(15-k)-1]
  function automatic logic [3:0] modelExp(input logic [15:0] x);
    int v;
    v = int'($signed(x));
    for (int k = 15; k >= 0; k--) begin
      if (v >= -(1 << (15 - k)) && v < (1 << (15 - k))) return 4'(k);
    end
    return 4'd0;
  endfunction

  function automatic logic [31:0] modelShift(input logic [15:0] x, input int s,
                                             input bit arith, input bit lo);
    logic [31:0] field;
    logic [63:0] prod;
    longint d, sv, q;
    if (lo) field = (arith && x[15]) ? {16'hFFFF, x} : {16'h0000, x};
    else    field = {x, 16'h0000};
    if (s >= 0) begin
      prod = {32'h0, field} * (64'd1 << s);
      return prod[31:0];
    end
    d = longint'(64'd1 << (-s));
    sv = longint'({32'h0, field});
    if (arith && field[31]) sv = sv - 64'sh1_0000_0000;
    q = sv / d;
    if (sv < 0 && q * d != sv) q = q - 1;
    return 32'(q);
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic doOp(input bit v, input logic [2:0] op, input logic [15:0] x,
                      input int amt, input bit lo, input bit clr, input string tag);
    logic [3:0] e;
    bit load;
    opValid = v; opCode = op; dataIn = x; shiftAmt = 6'(amt); posLo = lo; blkClr = clr;
    e = modelExp(x);
    if (v) begin
      case (op)
        3'd0: mRes = modelShift(x, amt, 1'b0, lo);
        3'd1: mRes = modelShift(x, amt, 1'b1, lo);
        3'd2: begin mRes = modelShift(x, int'(e), 1'b1, 1'b0); mExp = e; end
        3'd3: mRes = modelShift(x, -amt, 1'b1, lo);
        3'd4: mExp = e;
        default: ;
      endcase
    end
    load = v && (op == 3'd2 || op == 3'd4);
    if (clr) mBlk = load ? e : 4'd15;
    else if (load && e < mBlk) mBlk = e;
    @(negedge clk);
    check(tag, result, mRes);
    check(tag, {28'h0, expOut}, {28'h0, mExp});
    check((load || clr) ? "R9" : "R10", {28'h0, blkExp}, {28'h0, mBlk});
  endtask

  logic [15:0] words [12] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'hA5C3,
                              16'h1234, 16'hF00F, 16'h4000, 16'hC000, 16'h00FF, 16'hFF00};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", result, 32'h0);
    check("R1", {28'h0, expOut}, 32'h0);
    check("R1", {28'h0, blkExp}, 32'd15);
    rstN = 1'b1;

    // R3 R4 R5 shift sweep
    for (int w = 0; w < 12; w++)
      for (int lo = 0; lo < 2; lo++)
        for (int a = -32; a < 32; a++) begin
          doOp(1'b1, 3'd0, words[w], a, lo[0], 1'b0, lo != 0 ? "R3" : (a < 0 ? "R5" : "R4"));
          doOp(1'b1, 3'd1, words[w], a, lo[0], 1'b0, lo != 0 ? "R3" : (a < 0 ? "R5" : "R4"));
          doOp(1'b1, 3'd3, words[w], a, lo[0], 1'b0, "R8");
        end

    // R2 idle and unused codes hold
    doOp(1'b0, 3'd1, 16'h5555, 3, 1'b0, 1'b0, "R2");
    doOp(1'b1, 3'd5, 16'h0F0F, -4, 1'b1, 1'b0, "R2");
    doOp(1'b1, 3'd6, 16'h8001, 7, 1'b0, 1'b0, "R2");
    doOp(1'b1, 3'd7, 16'h0000, -32, 1'b1, 1'b0, "R2");

    // R9 clear alone
    doOp(1'b0, 3'd0, 16'h0000, 0, 1'b0, 1'b1, "R9");

    // R6 exhaustive derive exponent with periodic clears
    for (int i = 0; i < 65536; i++)
      doOp(1'b1, 3'd4, 16'(i), 0, 1'b0, (i % 4096) == 5, "R6");

    // R9 clear together with derive exponent, then R10 plain ops keep it
    doOp(1'b1, 3'd4, 16'h0F00, 0, 1'b0, 1'b1, "R9");
    for (int a = -8; a < 8; a++) begin
      doOp(1'b1, 3'd0, 16'h1357, a, a[0], 1'b0, "R10");
      doOp(1'b1, 3'd3, 16'hE001, a, a[1], 1'b0, "R10");
      doOp(1'b0, 3'd2, 16'h0000, a, 1'b0, 1'b0, "R10");
    end

    // R7 normalize: boundary words then a strided sweep
    for (int w = 0; w < 12; w++) doOp(1'b1, 3'd2, words[w], 5, 1'b1, 1'b0, "R7");
    for (int i = 3; i < 65536; i += 37)
      doOp(1'b1, 3'd2, 16'(i), (i % 64) - 32, i[0], (i % 1000) == 3, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule